// File: doc/BRIEF.md
# CSR Bus Window Decoder

This block connects one control/status register bus master to several subordinate register buses that share its data width. Each subordinate owns a contiguous, naturally aligned window of the master address space whose size is two to the power of that subordinate's address width. Windows are laid out one after another from address zero when the design is elaborated. A per-subordinate padding exponent can push a window up to a coarser power-of-two boundary.

For every master cycle the decoder compares the upper address bits against each window. It passes the low address bits, the write data and the read or write strobe to the one subordinate whose window matches. Subordinates answer a read one cycle after its strobe. The decoder records which window was addressed on each read strobe and uses that record to steer the returned data to the master. Back-to-back reads to different windows therefore come back in order, and a change of address in the following cycle cannot corrupt them. An address that falls in no window produces no strobe and reads back as zero.

Top module: `csr_win_decoder`

## Requirements
- R1: Windows are placed in index order from address 0, each window's base rounded up to a multiple of its own size. With two 10-bit subordinates, subordinate 0 answers 0x0000–0x03FF and subordinate 1 answers 0x0400–0x07FF.
- R2: A padding exponent k in SUB_ALIGN (8-bit field i belongs to subordinate i) rounds that window's base up to a multiple of 2^k. With two 10-bit subordinates and k = 12 for subordinate 1, subordinate 1 answers 0x1000–0x13FF.
- R3: Each subordinate's local address (LOC_W bits, field i of s_addr at bits [i*LOC_W +: LOC_W]) equals the low SUB_AW bits of the master address, zero-extended.
- R4: A master write strobe reaches only the subordinate whose window holds the address (bit i of s_w_stb). The write data is broadcast unchanged, and other subordinates' registers are left untouched.
- R5: A master read strobe reaches only the subordinate whose window holds the address (bit i of s_r_stb).
- R6: An address outside every window raises no subordinate strobe.
- R7: m_r_data shows the addressed subordinate's read data in the cycle after the read strobe.
- R8: Read strobes on consecutive cycles to different windows return each window's data in the following cycles, in issue order.
- R9: The data returned after a read is chosen by the window recorded at the strobe, not by the address present in the return cycle.
- R10: m_r_data is zero in any cycle that does not follow a read strobe, and in the cycle after a read to an address outside every window.
- R11: While and just after reset, with no strobe issued, m_r_data is zero and no subordinate strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | ADDR_W | Master address |
| m_r_stb | input | 1 | Master read strobe |
| m_w_stb | input | 1 | Master write strobe |
| m_w_data | input | DATA_W | Master write data |
| m_r_data | output | DATA_W | Read data returned to the master |
| s_addr | output | NUM_SUB*LOC_W | Local address per subordinate, field i at [i*LOC_W +: LOC_W] |
| s_r_stb | output | NUM_SUB | Read strobe per subordinate |
| s_w_stb | output | NUM_SUB | Write strobe per subordinate |
| s_w_data | output | DATA_W | Write data broadcast to all subordinates |
| s_r_data | input | NUM_SUB*DATA_W | Read data from subordinates, field i at [i*DATA_W +: DATA_W] |

## Verification
Strobes, local addresses and write data are combinational from the master inputs. They are checked in the same cycle: 1 ns after the inputs change, well before the next rising edge. Returned read data is due one rising edge after the read strobe. It is sampled at the following falling edge, with the address already moved on, so that a decode from the live address would show up as a mismatch. Writes land in the bench's subordinate models at the edge that samples the strobe, and they are confirmed through later reads over the same master port. The address decode is swept over the full 16-bit space against arithmetic window bounds for both the packed and the padded layout.

// File: rtl/csr_win_pkg.sv
package csr_win_pkg;

   // Exponent of the boundary a window must start on: its own size or the
   // requested padding, whichever is coarser.
   function automatic int place_log2(input int win_aw, input int pad_log2);
      return (pad_log2 > win_aw) ? pad_log2 : win_aw;
   endfunction

   // Round v up to the next multiple of 2^k.
   function automatic longint align_up(input longint v, input int k);
      longint mask;
      mask = (longint'(1) << k) - 1;
      return (v + mask) & ~mask;
   endfunction

endpackage

// File: rtl/csr_win_match.sv
module csr_win_match #(
   parameter int     ADDR_W = 16,
   parameter int     LOC_W  = 10,
   parameter int     WIN_AW = 10,
   parameter longint BASE   = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [LOC_W-1:0]  loc
);

   localparam logic [ADDR_W-1:0] BASE_V = BASE[ADDR_W-1:0];

   // Window selection from the bits above the window's own span
   generate
      if (WIN_AW >= ADDR_W) begin : g_full
         assign hit = 1'b1;
      end else begin : g_cmp
         assign hit = (addr[ADDR_W-1:WIN_AW] == BASE_V[ADDR_W-1:WIN_AW]);
      end
   endgenerate

   // Local address: low bits pass through, padded to the shared width
   generate
      if (WIN_AW == LOC_W) begin : g_loc_exact
         assign loc = addr[LOC_W-1:0];
      end else begin : g_loc_pad
         assign loc = {{(LOC_W-WIN_AW){1'b0}}, addr[WIN_AW-1:0]};
      end
   endgenerate

endmodule

// File: rtl/csr_win_rsel.sv
module csr_win_rsel #(
   parameter int NUM_SUB = 2,
   parameter int DATA_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      r_stb,
   input  logic [NUM_SUB-1:0]        hit,
   input  logic [NUM_SUB*DATA_W-1:0] sub_r_data,
   output logic [DATA_W-1:0]         r_data
);

   logic [NUM_SUB-1:0] sel_q;

   // Window recorded at each read strobe; cleared in every other cycle
   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (r_stb)
         sel_q <= hit;
      else
         sel_q <= '0;
   end

   // AND-OR return path steered by the recorded window
   always_comb begin
      r_data = '0;
      for (int i = 0; i < NUM_SUB; i++)
         r_data = r_data | ({DATA_W{sel_q[i]}} & sub_r_data[i*DATA_W +: DATA_W]);
   end

   // R8: at most one window recorded per read
   a_r8_one_window: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q));

   // R10: no read strobe, nothing returned
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !r_stb |=> (r_data == '0));

   // R10: a read that hit no window returns zero
   a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (r_stb && (hit == '0)) |=> (r_data == '0));

   generate
      for (genvar g = 0; g < NUM_SUB; g++) begin : g_ret_chk
         // R7/R9: data of the window hit at the strobe, whatever the address now
         a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
            (r_stb && hit[g]) |=> (r_data == sub_r_data[g*DATA_W +: DATA_W]));
      end
   endgenerate

endmodule

// File: rtl/csr_win_decoder.sv
module csr_win_decoder #(
   parameter int                   ADDR_W    = 16,
   parameter int                   DATA_W    = 8,
   parameter int                   NUM_SUB   = 2,
   parameter int                   LOC_W     = 10,
   parameter logic [NUM_SUB*8-1:0] SUB_AW    = {8'd10, 8'd10},
   parameter logic [NUM_SUB*8-1:0] SUB_ALIGN = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         m_addr,
   input  logic                      m_r_stb,
   input  logic                      m_w_stb,
   input  logic [DATA_W-1:0]         m_w_data,
   output logic [DATA_W-1:0]         m_r_data,
   output logic [NUM_SUB*LOC_W-1:0]  s_addr,
   output logic [NUM_SUB-1:0]        s_r_stb,
   output logic [NUM_SUB-1:0]        s_w_stb,
   output logic [DATA_W-1:0]         s_w_data,
   input  logic [NUM_SUB*DATA_W-1:0] s_r_data
);

   localparam longint SPACE = longint'(1) << ADDR_W;

   // Base of window idx: walk the earlier windows in order
   function automatic longint win_base(input int idx);
      longint cur;
      int     aw;
      int     k;
      cur = 0;
      for (int i = 0; i <= idx; i++) begin
         aw  = int'(SUB_AW[i*8 +: 8]);
         k   = csr_win_pkg::place_log2(aw, int'(SUB_ALIGN[i*8 +: 8]));
         cur = csr_win_pkg::align_up(cur, k);
         if (i < idx)
            cur = cur + (longint'(1) << aw);
      end
      return cur;
   endfunction

   // Elaboration-time parameter checks
   generate
      if (NUM_SUB < 1) begin : g_bad_num
         $error("csr_win_decoder: NUM_SUB must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("csr_win_decoder: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 62) begin : g_bad_addr
         $error("csr_win_decoder: ADDR_W must lie in 1..62");
      end
   endgenerate

   logic [NUM_SUB-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_SUB; g++) begin : g_win
         localparam int     AW_G   = int'(SUB_AW[g*8 +: 8]);
         localparam longint BASE_G = win_base(g);

         if (AW_G < 1 || AW_G > LOC_W || AW_G > ADDR_W) begin : g_bad_aw
            $error("csr_win_decoder: subordinate address width out of range");
         end
         if (BASE_G + (longint'(1) << AW_G) > SPACE) begin : g_bad_fit
            $error("csr_win_decoder: window extends past the address space");
         end

         logic [LOC_W-1:0] loc;

         csr_win_match #(
            .ADDR_W (ADDR_W),
            .LOC_W  (LOC_W),
            .WIN_AW (AW_G),
            .BASE   (BASE_G)
         ) u_match (
            .addr (m_addr),
            .hit  (hit[g]),
            .loc  (loc)
         );

         assign s_addr[g*LOC_W +: LOC_W] = loc;
         assign s_r_stb[g] = m_r_stb & hit[g];
         assign s_w_stb[g] = m_w_stb & hit[g];
      end
   endgenerate

   assign s_w_data = m_w_data;

   csr_win_rsel #(
      .NUM_SUB (NUM_SUB),
      .DATA_W  (DATA_W)
   ) u_rsel (
      .clk        (clk),
      .rst_n      (rst_n),
      .r_stb      (m_r_stb),
      .hit        (hit),
      .sub_r_data (s_r_data),
      .r_data     (m_r_data)
   );

   // R4: a subordinate write strobe needs a master write strobe
   a_r4_wstb_from_master: assert property (@(posedge clk) disable iff (!rst_n)
      (s_w_stb != '0) |-> m_w_stb);

   // R4: windows never overlap, so at most one write target
   a_r4_wstb_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_w_stb));

   // R5: a subordinate read strobe needs a master read strobe
   a_r5_rstb_from_master: assert property (@(posedge clk) disable iff (!rst_n)
      (s_r_stb != '0) |-> m_r_stb);

   // R5: at most one read target
   a_r5_rstb_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(s_r_stb) <= 1);

endmodule

// File: tb/csr_win_decoder_tb.sv
module csr_win_decoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int NS = 2;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic          m_r_stb = 1'b0;
   logic          m_w_stb = 1'b0;
   logic [DW-1:0] m_w_data = '0;

   logic [DW-1:0]    m_r_data;
   logic [NS*LW-1:0] s_addr;
   logic [NS-1:0]    s_r_stb;
   logic [NS-1:0]    s_w_stb;
   logic [DW-1:0]    s_w_data;
   logic [NS*DW-1:0] s_r_data;

   logic [DW-1:0]    p_r_data;
   logic [NS*LW-1:0] p_addr;
   logic [NS-1:0]    p_r_stb;
   logic [NS-1:0]    p_w_stb;
   logic [DW-1:0]    p_w_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_win_decoder #(
      .ADDR_W (AW), .DATA_W (DW), .NUM_SUB (NS), .LOC_W (LW),
      .SUB_AW ({8'd10, 8'd10}), .SUB_ALIGN ({8'd0, 8'd0})
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .m_addr (m_addr), .m_r_stb (m_r_stb),
      .m_w_stb (m_w_stb), .m_w_data (m_w_data), .m_r_data (m_r_data),
      .s_addr (s_addr), .s_r_stb (s_r_stb), .s_w_stb (s_w_stb),
      .s_w_data (s_w_data), .s_r_data (s_r_data)
   );

   // Padded layout: subordinate 1 starts on a 2^12 boundary
   csr_win_decoder #(
      .ADDR_W (AW), .DATA_W (DW), .NUM_SUB (NS), .LOC_W (LW),
      .SUB_AW ({8'd10, 8'd10}), .SUB_ALIGN ({8'd12, 8'd0})
   ) u_dut_pad (
      .clk (clk), .rst_n (rst_n), .m_addr (m_addr), .m_r_stb (m_r_stb),
      .m_w_stb (m_w_stb), .m_w_data (m_w_data), .m_r_data (p_r_data),
      .s_addr (p_addr), .s_r_stb (p_r_stb), .s_w_stb (p_w_stb),
      .s_w_data (p_w_data), .s_r_data ('0)
   );

   // Two register-file subordinates, one-cycle read latency, data held
   logic [DW-1:0] regs [NS][1024];
   logic [DW-1:0] rq   [NS];

   always @(posedge clk) begin
      for (int i = 0; i < NS; i++) begin
         if (s_w_stb[i]) regs[i][s_addr[i*LW +: LW]] <= s_w_data;
         if (s_r_stb[i]) rq[i] <= regs[i][s_addr[i*LW +: LW]];
      end
   end

   always_comb begin
      for (int i = 0; i < NS; i++) s_r_data[i*DW +: DW] = rq[i];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      m_addr = a; m_w_data = d; m_w_stb = 1'b1;
      @(negedge clk);
      m_w_stb = 1'b0;
   endtask

   // Single read: strobe for one cycle, sample one edge later
   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      m_addr = a; m_r_stb = 1'b1;
      @(negedge clk);
      m_r_stb = 1'b0;
      #1 chk(tag, 32'(m_r_data), 32'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 chk("R11 r_data in reset", 32'(m_r_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk("R11 r_data after reset", 32'(m_r_data), 0);
      chk("R11 strobes after reset", {28'd0, s_r_stb, s_w_stb}, 0);

      // Seed registers in both windows
      wr(16'h0003, 8'h33);
      wr(16'h0000, 8'h55);
      wr(16'h0402, 8'haa);
      // R4: same local address in the other window must leave window 0 alone
      wr(16'h0403, 8'h66);
      chk("R4 write data broadcast", 32'(s_w_data), 32'h66);

      rd(16'h0003, 8'h33, "R4 window0 reg3 untouched");
      rd(16'h0403, 8'h66, "R7 window1 reg3");
      rd(16'h0402, 8'haa, "R7 window1 reg2 via 0x0402");

      // R8: back-to-back reads to different windows
      @(negedge clk);
      m_addr = 16'h0000; m_r_stb = 1'b1;
      @(negedge clk);
      m_addr = 16'h0402;
      #1 chk("R8 first return window0", 32'(m_r_data), 32'h55);
      @(negedge clk);
      // R9: address now points at window 0, data must still be window 1's
      m_r_stb = 1'b0; m_addr = 16'h0000;
      #1 chk("R8 R9 second return window1", 32'(m_r_data), 32'haa);
      @(negedge clk);
      #1 chk("R10 idle cycle returns zero", 32'(m_r_data), 0);

      // R6/R10: read outside every window
      @(negedge clk);
      m_addr = 16'h0900; m_r_stb = 1'b1;
      #1 chk("R6 no read strobe on miss", 32'(s_r_stb), 0);
      @(negedge clk);
      m_r_stb = 1'b0;
      #1 chk("R10 miss returns zero", 32'(m_r_data), 0);

      // R9: window 1 read, then address moves to window 0 in the return cycle
      @(negedge clk);
      m_addr = 16'h0403; m_r_stb = 1'b1;
      @(negedge clk);
      m_r_stb = 1'b0; m_addr = 16'h0003;
      #1 chk("R9 return follows recorded window", 32'(m_r_data), 32'h66);

      // Full-space sweep with both strobes high, four addresses per cycle
      @(negedge clk);
      m_r_stb = 1'b1; m_w_stb = 1'b1; m_w_data = 8'h00;
      for (int base = 0; base < 65536; base += 4) begin
         @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            int a;
            logic [1:0] e_pk;
            logic [1:0] e_pd;
            a = base + k;
            m_addr = AW'(a);
            #1;
            e_pk = {(a >= 32'h400 && a < 32'h800), (a < 32'h400)};
            e_pd = {(a >= 32'h1000 && a < 32'h1400), (a < 32'h400)};
            chk("R1 R4 R6 write strobe decode", 32'(s_w_stb), 32'(e_pk));
            chk("R5 R6 read strobe decode", 32'(s_r_stb), 32'(e_pk));
            chk("R2 padded window decode", 32'(p_w_stb), 32'(e_pd));
            chk("R3 local addresses", 32'(s_addr), {12'd0, a[9:0], a[9:0]});
         end
      end
      @(negedge clk);
      m_r_stb = 1'b0; m_w_stb = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule